// File: doc/BRIEF.md
# Trap and Exception Control Unit

This unit keeps the system-control state of a small 32-bit processor core: a six-bit status word holding a two-deep stack of mode and interrupt-enable bits, a cause word, the exception return address and a fixed processor identifier. In every cycle it weighs a software trap request, which carries its own exception code, against a set of hardware interrupt lines. When either one wins, it takes the trap within that same cycle. It raises a redirect to a fixed vector, tells the pipeline to discard the current instruction's write-back, and on the next clock edge updates status, cause and return address.

The same unit serves the privileged register path. An index selects one of four readable registers, and writes reach status and the return address. Both paths, and the return-from-exception instruction word, work only while the status word shows kernel mode. Hardware line 0 cannot be masked. The other lines need the interrupt-enable bit. By default each line fires on its rising edge, and an edge that loses arbitration is held pending until it can be taken.

Top module: `trap_ctrl`

## Requirements
- R1: On a taken trap the cause register becomes: bit 31 = the delay-slot input, bits 6:2 = the exception code, every other bit 0.
- R2: On a taken trap status bits 5:2 take the old bits 3:0, bit 0 keeps its value and bit 1 becomes 1 (kernel mode).
- R3: On a taken trap the return-address register gets the instruction PC, or the PC minus 4 when the delay-slot input is 1.
- R4: A software trap records the code it presents (8 system call, 9 breakpoint); a hardware interrupt records code 0.
- R5: When a software request and a hardware interrupt arrive in one cycle, the software trap is taken; the interrupt is kept pending and taken in the next cycle without a software request.
- R6: Interrupt line 0 is taken regardless of status bit 0; a rising edge on lines 1..7 is taken only while status bit 0 is 1 and is otherwise dropped.
- R7: `trap_taken` and `squash` are 1 in exactly the cycle a trap is taken, with `trap_vector` equal to the vector parameter; a line held high causes only one trap.
- R8: Register index 12 reads {26'b0, status[5:0]}, 13 reads cause, 14 reads the return address, 15 reads 0x00000200; other indices read 0. Reads are combinational and show the state before this cycle's edge.
- R9: After reset status reads 0x02 and cause and return address read 0.
- R10: While status bit 1 is 0, reads return 0, and register writes and the return-from-exception word change nothing.
- R11: The instruction word 0x42000010 in kernel mode sets status bits 3:0 to the old bits 5:2, keeping bits 5:4.
- R12: In the cycle a trap is taken, a register write and a return-from-exception are both discarded.
- R13: A kernel-mode write to index 12 loads status from data bits 5:0, one to index 14 loads the return address; writes to 13 and 15 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sw_trap_req | input | 1 | Software trap requested by the current instruction |
| sw_trap_code | input | 5 | Exception code of the software trap |
| irq_lines | input | NUM_IRQ | Hardware interrupt lines, line 0 non-maskable |
| instr_pc | input | 32 | PC of the current instruction |
| instr_in_slot | input | 1 | Current instruction sits in a branch delay slot |
| instr_word | input | 32 | Current instruction word, decoded for return-from-exception |
| reg_wr_en | input | 1 | Privileged register write strobe |
| reg_idx | input | 5 | Register index for read and write |
| reg_wr_data | input | 32 | Privileged register write data |
| reg_rd_data | output | 32 | Privileged register read data |
| trap_taken | output | 1 | A trap is taken this cycle |
| trap_vector | output | 32 | Redirect address for the taken trap |
| squash | output | 1 | Discard the current instruction's write-back |

## Verification
The bench builds the unit with eight interrupt lines, rising-edge sensing, a vector of 0x80000080 and the default identifier. Eight lines let it tell the unmaskable line apart from a masked one and from an enabled one. Edge sensing with the pending flag lets it check that a held line traps only once, and that an interrupt losing to a software trap is taken in the next cycle. Ignored user-mode writes and returns are shown through the status value that the next trap pushes.

// File: rtl/trap_ctrl_pkg.sv
package trap_ctrl_pkg;
   localparam int WORD_W = 32;
   localparam int STAT_W = 6;
   localparam int CODE_W = 5;
   localparam int IDX_W  = 5;
   localparam int CAUSE_PAD = WORD_W - 3 - CODE_W;

   localparam logic [IDX_W-1:0] IDX_STATUS = 5'd12;
   localparam logic [IDX_W-1:0] IDX_CAUSE  = 5'd13;
   localparam logic [IDX_W-1:0] IDX_EPC    = 5'd14;
   localparam logic [IDX_W-1:0] IDX_PRID   = 5'd15;

   localparam logic [CODE_W-1:0] CODE_HWINT = 5'd0;
   localparam logic [WORD_W-1:0] RFE_WORD   = 32'h4200_0010;
   localparam logic [STAT_W-1:0] STAT_RESET = 6'h02;
endpackage

// File: rtl/trap_irq_detect.sv
module trap_irq_detect
   import trap_ctrl_pkg::*;
#(
   parameter int NUM_IRQ  = 8,
   parameter bit IRQ_EDGE = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_IRQ-1:0] lines_i,
   input  logic               ie_i,
   input  logic               grant_i,
   output logic               req_o
);
   if (NUM_IRQ < 2) begin : g_bad_num
      $error("trap_irq_detect: NUM_IRQ must be at least 2");
   end

   if (IRQ_EDGE) begin : g_edge
      logic [NUM_IRQ-1:0] prev_q;
      logic [NUM_IRQ-1:0] rise;
      logic               pend_q;
      logic               qual;

      assign rise  = lines_i & ~prev_q;
      assign qual  = rise[0] | (ie_i & (|rise[NUM_IRQ-1:1]));
      assign req_o = pend_q | qual;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            prev_q <= '0;
            pend_q <= 1'b0;
         end else begin
            prev_q <= lines_i;
            pend_q <= grant_i ? 1'b0 : (pend_q | qual);
         end
      end

      p_pend_kept_r5: assert property (@(posedge clk) disable iff (!rst_n)
         (req_o && !grant_i) |=> req_o);
   end else begin : g_level
      logic unused_lvl;
      assign unused_lvl = grant_i ^ clk ^ rst_n;
      assign req_o = lines_i[0] | (ie_i & (|lines_i[NUM_IRQ-1:1]));
   end
endmodule

// File: rtl/trap_arbiter.sv
module trap_arbiter
   import trap_ctrl_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sw_req_i,
   input  logic [CODE_W-1:0] sw_code_i,
   input  logic              hw_req_i,
   output logic              trap_o,
   output logic [CODE_W-1:0] code_o,
   output logic              hw_grant_o
);
   assign trap_o     = sw_req_i | hw_req_i;
   assign hw_grant_o = hw_req_i & ~sw_req_i;
   assign code_o     = sw_req_i ? sw_code_i : CODE_HWINT;

   p_sw_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
      sw_req_i |-> (trap_o && code_o == sw_code_i && !hw_grant_o));

   p_hw_code_r4: assert property (@(posedge clk) disable iff (!rst_n)
      hw_grant_o |-> (trap_o && code_o == 5'd0));
endmodule

// File: rtl/trap_state.sv
module trap_state
   import trap_ctrl_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              trap_i,
   input  logic [CODE_W-1:0] code_i,
   input  logic [WORD_W-1:0] pc_i,
   input  logic              ds_i,
   input  logic              rfe_i,
   input  logic              wr_en_i,
   input  logic [IDX_W-1:0]  wr_idx_i,
   input  logic [WORD_W-1:0] wr_data_i,
   output logic [STAT_W-1:0] status_o,
   output logic [WORD_W-1:0] cause_o,
   output logic [WORD_W-1:0] epc_o
);
   localparam logic [WORD_W-1:0] WORD_STEP = WORD_W'(4);

   logic wr_status, wr_epc;
   assign wr_status = wr_en_i && (wr_idx_i == IDX_STATUS);
   assign wr_epc    = wr_en_i && (wr_idx_i == IDX_EPC);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         status_o <= STAT_RESET;
         cause_o  <= '0;
         epc_o    <= '0;
      end else if (trap_i) begin
         status_o <= {status_o[3:0], 1'b1, status_o[0]};
         cause_o  <= {ds_i, {CAUSE_PAD{1'b0}}, code_i, 2'b00};
         epc_o    <= ds_i ? (pc_i - WORD_STEP) : pc_i;
      end else begin
         if (rfe_i)     status_o <= {status_o[5:4], status_o[5:2]};
         if (wr_status) status_o <= wr_data_i[STAT_W-1:0];
         if (wr_epc)    epc_o    <= wr_data_i;
      end
   end

   p_cause_fmt_r1: assert property (@(posedge clk) disable iff (!rst_n)
      trap_i |=> (cause_o[31] == $past(ds_i) && cause_o[6:2] == $past(code_i)
                  && cause_o[30:7] == '0 && cause_o[1:0] == 2'b00));

   p_stat_push_r2: assert property (@(posedge clk) disable iff (!rst_n)
      trap_i |=> (status_o[5:2] == $past(status_o[3:0]) && status_o[1]
                  && status_o[0] == $past(status_o[0])));

   p_epc_slot_r3: assert property (@(posedge clk) disable iff (!rst_n)
      trap_i |=> (epc_o == ($past(ds_i) ? $past(pc_i) - 32'd4 : $past(pc_i))));

   p_user_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!status_o[1] && !trap_i) |=> ($stable(status_o) && $stable(epc_o)));

   p_rfe_pop_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (rfe_i && !trap_i && !wr_status) |=>
         (status_o[3:0] == $past(status_o[5:2]) && $stable(status_o[5:4])));
endmodule

// File: rtl/trap_ctrl.sv
module trap_ctrl
   import trap_ctrl_pkg::*;
#(
   parameter int          NUM_IRQ  = 8,
   parameter bit          IRQ_EDGE = 1'b1,
   parameter logic [31:0] TRAP_VEC = 32'h8000_0080,
   parameter logic [31:0] PROC_ID  = 32'h0000_0200
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               sw_trap_req,
   input  logic [4:0]         sw_trap_code,
   input  logic [NUM_IRQ-1:0] irq_lines,
   input  logic [31:0]        instr_pc,
   input  logic               instr_in_slot,
   input  logic [31:0]        instr_word,
   input  logic               reg_wr_en,
   input  logic [4:0]         reg_idx,
   input  logic [31:0]        reg_wr_data,
   output logic [31:0]        reg_rd_data,
   output logic               trap_taken,
   output logic [31:0]        trap_vector,
   output logic               squash
);
   if (TRAP_VEC[1:0] != 2'b00) begin : g_bad_vec
      $error("trap_ctrl: TRAP_VEC must be word aligned");
   end

   logic [STAT_W-1:0] status;
   logic [WORD_W-1:0] cause, epc;
   logic              kernel, hw_req, hw_grant, trap, rfe, wr_ok;
   logic [CODE_W-1:0] code;

   assign kernel = status[1];
   assign rfe    = kernel && (instr_word == RFE_WORD);
   assign wr_ok  = kernel && reg_wr_en;

   trap_irq_detect #(.NUM_IRQ(NUM_IRQ), .IRQ_EDGE(IRQ_EDGE)) u_irq (
      .clk(clk), .rst_n(rst_n), .lines_i(irq_lines), .ie_i(status[0]),
      .grant_i(hw_grant), .req_o(hw_req));

   trap_arbiter u_arb (
      .clk(clk), .rst_n(rst_n), .sw_req_i(sw_trap_req), .sw_code_i(sw_trap_code),
      .hw_req_i(hw_req), .trap_o(trap), .code_o(code), .hw_grant_o(hw_grant));

   trap_state u_state (
      .clk(clk), .rst_n(rst_n), .trap_i(trap), .code_i(code), .pc_i(instr_pc),
      .ds_i(instr_in_slot), .rfe_i(rfe), .wr_en_i(wr_ok), .wr_idx_i(reg_idx),
      .wr_data_i(reg_wr_data), .status_o(status), .cause_o(cause), .epc_o(epc));

   always_comb begin
      reg_rd_data = '0;
      if (kernel) begin
         unique case (reg_idx)
            IDX_STATUS: reg_rd_data = {{(WORD_W-STAT_W){1'b0}}, status};
            IDX_CAUSE:  reg_rd_data = cause;
            IDX_EPC:    reg_rd_data = epc;
            IDX_PRID:   reg_rd_data = PROC_ID;
            default:    reg_rd_data = '0;
         endcase
      end
   end

   assign trap_taken  = trap;
   assign squash      = trap;
   assign trap_vector = TRAP_VEC;

   p_user_rd_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !status[1] |-> (reg_rd_data == 32'd0));

   p_kernel_after_trap_r7: assert property (@(posedge clk) disable iff (!rst_n)
      trap_taken |=> (reg_idx != IDX_STATUS || reg_rd_data[1]));
endmodule

// File: tb/sim_trap_ctrl.sv
module sim_trap_ctrl;
   localparam int          CLK_P = 10;
   localparam logic [31:0] VEC   = 32'h8000_0080;

   typedef struct {
      bit          t;
      bit          c;
      logic [31:0] r;
      string       tag;
   } item_t;

   logic clk = 1'b0, rst_n = 1'b0;
   logic sw_trap_req = 0, instr_in_slot = 0, reg_wr_en = 0;
   logic [4:0] sw_trap_code = 0, reg_idx = 0;
   logic [7:0] irq_lines = 0;
   logic [31:0] instr_pc = 0, instr_word = 0, reg_wr_data = 0;
   logic [31:0] reg_rd_data, trap_vector;
   logic trap_taken, squash;

   logic n_sw = 0, n_ds = 0, n_wr = 0;
   logic [4:0] n_code = 0, n_idx = 0;
   logic [7:0] n_irq = 0;
   logic [31:0] n_pc = 0, n_word = 0, n_wdata = 0;

   item_t q[$];
   int n_cmp = 0, n_bad = 0;
   bit done = 0;

   trap_ctrl #(.NUM_IRQ(8), .IRQ_EDGE(1'b1), .TRAP_VEC(VEC)) u0 (
      .clk(clk), .rst_n(rst_n), .sw_trap_req(sw_trap_req), .sw_trap_code(sw_trap_code),
      .irq_lines(irq_lines), .instr_pc(instr_pc), .instr_in_slot(instr_in_slot),
      .instr_word(instr_word), .reg_wr_en(reg_wr_en), .reg_idx(reg_idx),
      .reg_wr_data(reg_wr_data), .reg_rd_data(reg_rd_data), .trap_taken(trap_taken),
      .trap_vector(trap_vector), .squash(squash));

   always #(CLK_P/2) clk = ~clk;

   task automatic dflt();
      n_sw = 0; n_code = 0; n_ds = 0; n_pc = 0; n_word = 0;
      n_wr = 0; n_idx = 0; n_wdata = 0;
   endtask

   task automatic tick(input bit et, input bit cr, input logic [31:0] er, input string tag);
      item_t it;
      @(negedge clk);
      sw_trap_req = n_sw; sw_trap_code = n_code; irq_lines = n_irq;
      instr_pc = n_pc; instr_in_slot = n_ds; instr_word = n_word;
      reg_wr_en = n_wr; reg_idx = n_idx; reg_wr_data = n_wdata;
      it.t = et; it.c = cr; it.r = er; it.tag = tag;
      q.push_back(it);
   endtask

   task automatic rd(input logic [4:0] idx, input logic [31:0] er, input string tag);
      dflt(); n_idx = idx;
      tick(0, 1, er, tag);
   endtask

   initial begin : monitor
      item_t it;
      forever begin
         @(negedge clk);
         #(CLK_P/4);
         if (q.size() > 0) begin
            it = q.pop_front();
            n_cmp++;
            if (trap_taken !== it.t || squash !== it.t) begin
               n_bad++;
               $display("FAIL %s trap/squash: actual %b/%b expected %b", it.tag, trap_taken, squash, it.t);
            end
            if (it.t) begin
               n_cmp++;
               if (trap_vector !== VEC) begin
                  n_bad++;
                  $display("FAIL %s vector: actual %h expected %h", it.tag, trap_vector, VEC);
               end
            end
            if (it.c) begin
               n_cmp++;
               if (reg_rd_data !== it.r) begin
                  n_bad++;
                  $display("FAIL %s read: actual %h expected %h", it.tag, reg_rd_data, it.r);
               end
            end
         end
      end
   end

   initial begin : watchdog
      #(CLK_P * 5000);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog expired");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin : driver
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R9 reset state, R8 read map
      rd(5'd12, 32'h02, "R9 status after reset");
      rd(5'd13, 32'h0, "R9 cause after reset");
      rd(5'd14, 32'h0, "R9 epc after reset");
      rd(5'd15, 32'h200, "R8 processor id");
      rd(5'd3, 32'h0, "R8 unmapped index");
      // R13 writes
      dflt(); n_wr = 1; n_idx = 5'd12; n_wdata = 32'hFFFF_FF07;
      tick(0, 1, 32'h02, "R8 read shows old state");
      rd(5'd12, 32'h07, "R13 status write");
      dflt(); n_wr = 1; n_idx = 5'd14; n_wdata = 32'h1234_5678; tick(0, 0, 0, "R13 epc write");
      rd(5'd14, 32'h1234_5678, "R13 epc readback");
      dflt(); n_wr = 1; n_idx = 5'd13; n_wdata = 32'hFFFF_FFFF; tick(0, 0, 0, "R13 cause write");
      rd(5'd13, 32'h0, "R13 cause read-only");
      // software traps R1 R2 R3 R4
      dflt(); n_sw = 1; n_code = 5'd8; n_pc = 32'h100; tick(1, 0, 0, "R7 syscall trap");
      rd(5'd13, 32'h20, "R1 R4 syscall cause");
      rd(5'd14, 32'h100, "R3 epc no slot");
      rd(5'd12, 32'h1F, "R2 status push");
      dflt(); n_sw = 1; n_code = 5'd9; n_pc = 32'h200; n_ds = 1; tick(1, 0, 0, "R7 break trap");
      rd(5'd13, 32'h8000_0024, "R1 R4 break cause in slot");
      rd(5'd14, 32'h1FC, "R3 epc in slot");
      rd(5'd12, 32'h3F, "R2 status push again");
      // R11 return from exception
      dflt(); n_wr = 1; n_idx = 5'd12; n_wdata = 32'h2B; tick(0, 0, 0, "R13 set status");
      dflt(); n_word = 32'h4200_0010; tick(0, 0, 0, "R11 rfe");
      rd(5'd12, 32'h2A, "R11 status pop");
      dflt(); n_wr = 1; n_idx = 5'd12; n_wdata = 32'h23; tick(0, 0, 0, "R13 set status");
      dflt(); n_word = 32'h4200_0010; tick(0, 0, 0, "R11 rfe to user");
      // R10 user mode
      rd(5'd15, 32'h0, "R10 user read zero");
      dflt(); n_wr = 1; n_idx = 5'd12; n_wdata = 32'h02; tick(0, 0, 0, "R10 user write");
      dflt(); n_word = 32'h4200_0010; tick(0, 0, 0, "R10 user rfe");
      // R6 nmi in user mode, IE=0
      dflt(); n_irq = 8'h01; n_pc = 32'h300; tick(1, 0, 0, "R6 nmi taken");
      dflt(); n_irq = 8'h00;
      rd(5'd12, 32'h22, "R10 ignored writes seen in push");
      rd(5'd13, 32'h0, "R4 hw cause code zero");
      rd(5'd14, 32'h300, "R3 nmi epc");
      // R6 masked line
      dflt(); n_irq = 8'h08; tick(0, 0, 0, "R6 masked line ignored");
      dflt(); n_irq = 8'h00; tick(0, 0, 0, "R6 line low");
      rd(5'd12, 32'h22, "R6 status untouched by masked line");
      dflt(); n_wr = 1; n_idx = 5'd12; n_wdata = 32'h23; tick(0, 0, 0, "R13 enable irq");
      dflt(); n_irq = 8'h08; n_pc = 32'h400; n_ds = 1; tick(1, 0, 0, "R6 enabled line taken");
      dflt(); n_irq = 8'h08; tick(0, 0, 0, "R7 held line single trap");
      dflt(); n_irq = 8'h00;
      rd(5'd13, 32'h8000_0000, "R1 hw cause in slot");
      rd(5'd14, 32'h3FC, "R3 hw epc in slot");
      rd(5'd12, 32'h0F, "R2 push from 0x23");
      // R5 priority
      dflt(); n_irq = 8'h20; n_sw = 1; n_code = 5'd8; n_pc = 32'h500; tick(1, 0, 0, "R5 sw wins");
      dflt(); n_irq = 8'h20; n_pc = 32'h504; n_idx = 5'd13;
      tick(1, 1, 32'h20, "R5 pending hw next cycle");
      dflt(); n_irq = 8'h00;
      rd(5'd13, 32'h0, "R5 deferred hw code");
      rd(5'd14, 32'h504, "R5 deferred epc");
      rd(5'd12, 32'h3F, "R2 status after two traps");
      // R12 write lost under trap
      dflt(); n_sw = 1; n_code = 5'd9; n_pc = 32'h600; n_wr = 1; n_idx = 5'd12; n_wdata = 32'h0;
      tick(1, 0, 0, "R12 trap with write");
      dflt(); n_sw = 1; n_code = 5'd8; n_pc = 32'h700; n_wr = 1; n_idx = 5'd14; n_wdata = 32'hAAAA;
      n_word = 32'h4200_0010;
      tick(1, 0, 0, "R12 trap with epc write and rfe");
      rd(5'd12, 32'h3F, "R12 status write and rfe dropped");
      rd(5'd14, 32'h700, "R12 epc write dropped");
      rd(5'd0, 32'h0, "R8 index zero");
      repeat (3) begin
         dflt(); tick(0, 0, 0, "R7 idle");
      end
      wait (q.size() == 0);
      @(negedge clk);
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule